// File: doc/BRIEF.md
# Trace Unit Power-Down Status Register

This block is a read-only 32-bit status word for a debug trace unit. It sits in the always-on power domain and tells software, or an external debugger, two things. The first is whether the trace unit's core power domain is up and out of reset. The second is whether the trace unit's register state was lost since the word was last read. It also raises an error indication for accesses to the trace unit's other registers while those registers cannot be used.

The state-lost indication is a sticky flag. Losing core power, or holding the core domain in reset, sets the flag. A read clears it, but only when the core domain is up, and not when the read comes through the memory-mapped port while the software lock is engaged. The read word is registered: a read strobe captures it at the clock edge, and the flag clears at that same edge. The returned value is therefore always the value from before the clear.

Two parameters pick variants. `LEGACY_ERR` makes a set flag also produce error responses on trace-register accesses. `ONE_DOMAIN` models a unit with a single power domain, whose word always reads as 0x00000001.

Top module: `trc_pwrdn_status`

## Requirements
- R1: Read-data bits [31:6] and [4:2] are always 0.
- R2: Bit 0 of the word captured by a read is 1 exactly when `core_pwr_up` is 1 and `core_rst` is 0 in the read cycle.
- R3: In every cycle where `trc_acc` is 1 while the core domain is down or in reset, `acc_err` is 1 in that same cycle.
- R4: While the core domain is down or in reset, the sticky flag is set to 1. A read in that state returns 1 in bit 1 and leaves the flag set.
- R5: A read while the core domain is up and out of reset returns the current flag in bit 1, then clears the flag. An immediately following read returns 0 in bit 1.
- R6: A read with `rd_mmap`=1 (memory-mapped port) while `sw_lock`=1 does not clear the flag. A read with `rd_mmap`=0 (external debugger) clears it regardless of `sw_lock`.
- R7: Bit 5 of the captured word equals `os_lock` while `core_pwr_up` is 1, and is 0 while `core_pwr_up` is 0.
- R8: With `LEGACY_ERR`=1, a trace-register access while the flag is set gives `acc_err`=1 even with the core domain up. With `LEGACY_ERR`=0, the flag has no effect on `acc_err`.
- R9: With `ONE_DOMAIN`=1, every read returns 0x00000001 and `acc_err` stays 0.
- R10: After the always-on reset, `rd_data` is 0 and the flag is 1. The first read with the core domain up therefore returns 1 in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Always-on reset, active low |
| core_pwr_up | input | 1 | Core power domain is powered |
| core_rst | input | 1 | Core power domain is held in reset |
| os_lock | input | 1 | OS-lock locked indication |
| sw_lock | input | 1 | Software lock engaged |
| rd_en | input | 1 | Read strobe for the status word |
| rd_mmap | input | 1 | 1: read via memory-mapped port, 0: via external debugger |
| trc_acc | input | 1 | Strobe for an access to another trace register |
| rd_data | output | 32 | Status word captured by the last read |
| acc_err | output | 1 | Error response for the current trace-register access |

## Verification
The case hardest to reach from the ports is a flag that survives a read. This needs a memory-mapped read with the software lock engaged while the core domain is up, right after a power-down has set the flag. A clean random stream clears the flag quickly, so the flag is rarely set in that situation. Directed sequences power the core down, bring it back, and then issue locked memory-mapped reads followed by an external debugger read. The random phase biases power and reset toward the up state, so clears and re-sets interleave with lock and port choices. Three instances run side by side on the same stimulus (default, legacy error mode and single domain) so that the error output can be compared between the modes.

// File: rtl/trc_pwrdn_status.sv
`timescale 1ns/1ps
module trc_pwrdn_status #(
  parameter bit LEGACY_ERR = 1'b0,
  parameter bit ONE_DOMAIN = 1'b0,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_pwr_up,
  input  logic              core_rst,
  input  logic              os_lock,
  input  logic              sw_lock,
  input  logic              rd_en,
  input  logic              rd_mmap,
  input  logic              trc_acc,
  output logic [DATA_W-1:0] rd_data,
  output logic              acc_err
);

  localparam int PAD_W = DATA_W - 6;

  logic core_ok;
  logic lost_q;
  logic clr_ok;
  logic [DATA_W-1:0] word;

  assign core_ok = core_pwr_up & ~core_rst;
  assign clr_ok  = rd_en & core_ok & ~(sw_lock & rd_mmap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lost_q <= 1'b1;
    else if (!core_ok) lost_q <= 1'b1;
    else if (clr_ok)   lost_q <= 1'b0;
  end

  assign word = ONE_DOMAIN ? {{(DATA_W-1){1'b0}}, 1'b1}
                           : {{PAD_W{1'b0}}, core_pwr_up & os_lock, 3'b000,
                              ~core_ok | lost_q, core_ok};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= word;
  end

  assign acc_err = ~ONE_DOMAIN & trc_acc & (~core_ok | (LEGACY_ERR & lost_q));

  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:6] == '0 && rd_data[4:2] == 3'b000);

  assert_bit0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !ONE_DOMAIN |=> rd_data[0] == $past(core_pwr_up && !core_rst));

  assert_err_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trc_acc && !ONE_DOMAIN && (!core_pwr_up || core_rst) |-> acc_err);

  assert_set_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !core_pwr_up || core_rst |=> lost_q);

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && core_pwr_up && !core_rst && !(sw_lock && rd_mmap) |=> !lost_q);

  assert_lock_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && sw_lock && rd_mmap && lost_q |=> lost_q);

  assert_oslock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !ONE_DOMAIN |=> rd_data[5] == $past(core_pwr_up && os_lock));

  assert_new_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !LEGACY_ERR && core_pwr_up && !core_rst |-> !acc_err);

  assert_one_dom_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ONE_DOMAIN |-> !acc_err && (rd_data == '0 || rd_data == 1));

endmodule

// File: tb/trc_pwrdn_status_bench.sv
`timescale 1ns/1ps
module trc_pwrdn_status_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up = 1'b0, crst = 1'b1, osl = 1'b0, swl = 1'b0, rd = 1'b0, mm = 1'b0, trc = 1'b0;
  logic [31:0] d_new, d_leg, d_one;
  logic e_new, e_leg, e_one;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic m_lost;
  logic [31:0] m_rd, m_rd_one;

  always #5 clk = ~clk;

  trc_pwrdn_status #(.LEGACY_ERR(1'b0), .ONE_DOMAIN(1'b0)) u_trc_pwrdn_status (
    .clk(clk), .rst_n(rst_n), .core_pwr_up(up), .core_rst(crst), .os_lock(osl),
    .sw_lock(swl), .rd_en(rd), .rd_mmap(mm), .trc_acc(trc), .rd_data(d_new), .acc_err(e_new));
  trc_pwrdn_status #(.LEGACY_ERR(1'b1), .ONE_DOMAIN(1'b0)) u_trc_pwrdn_status_leg (
    .clk(clk), .rst_n(rst_n), .core_pwr_up(up), .core_rst(crst), .os_lock(osl),
    .sw_lock(swl), .rd_en(rd), .rd_mmap(mm), .trc_acc(trc), .rd_data(d_leg), .acc_err(e_leg));
  trc_pwrdn_status #(.LEGACY_ERR(1'b0), .ONE_DOMAIN(1'b1)) u_trc_pwrdn_status_one (
    .clk(clk), .rst_n(rst_n), .core_pwr_up(up), .core_rst(crst), .os_lock(osl),
    .sw_lock(swl), .rd_en(rd), .rd_mmap(mm), .trc_acc(trc), .rd_data(d_one), .acc_err(e_one));

  function automatic logic [31:0] exp_word(input logic p, input logic r, input logic o,
                                           input logic lost);
    logic ok;
    ok = p & ~r;
    exp_word = 32'd0;
    exp_word[0] = ok;
    exp_word[1] = ~ok | lost;
    exp_word[5] = p & o;
  endfunction

  function automatic logic exp_err(input logic legacy, input logic p, input logic r,
                                   input logic t, input logic lost);
    exp_err = t & (~(p & ~r) | (legacy & lost));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic p, input logic r, input logic o, input logic s,
                      input logic rdi, input logic m, input logic t, input string tag);
    logic ok;
    up = p; crst = r; osl = o; swl = s; rd = rdi; mm = m; trc = t;
    #1;
    chk({tag, " R3 err new"}, {31'd0, e_new}, {31'd0, exp_err(1'b0, p, r, t, m_lost)});
    chk({tag, " R8 err legacy"}, {31'd0, e_leg}, {31'd0, exp_err(1'b1, p, r, t, m_lost)});
    chk({tag, " R9 err one"}, {31'd0, e_one}, 32'd0);
    ok = p & ~r;
    if (rdi) begin
      m_rd = exp_word(p, r, o, m_lost);
      m_rd_one = 32'd1;
    end
    if (!ok) m_lost = 1'b1;
    else if (rdi && !(s && m)) m_lost = 1'b0;
    @(posedge clk);
    @(negedge clk);
    if (rdi) begin
      chk({tag, " R1 R2 R5 R7 word"}, d_new, m_rd);
      chk({tag, " R4 R6 word legacy"}, d_leg, m_rd);
      chk({tag, " R9 word one"}, d_one, m_rd_one);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_lost = 1'b1;
    m_rd = 32'd0;
    m_rd_one = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset data", d_new, 32'd0);
    chk("R10 reset data one", d_one, 32'd0);

    step(1, 0, 0, 0, 1, 0, 0, "R10 first read");
    chk("R10 flag after reset", d_new, 32'h3);
    step(1, 0, 1, 0, 1, 0, 0, "R5 second read");
    chk("R5 cleared", d_new, 32'h21);

    step(0, 0, 1, 0, 0, 0, 1, "R4 power down");
    step(0, 0, 1, 0, 1, 1, 0, "R4 read down");
    chk("R7 bit5 zero down", d_new, 32'h2);
    step(0, 0, 1, 0, 1, 0, 0, "R4 read down again");
    chk("R4 flag kept", d_new, 32'h2);

    step(1, 0, 1, 1, 0, 0, 1, "R8 up with flag");
    step(1, 0, 1, 1, 1, 1, 0, "R6 locked mmap read");
    chk("R6 flag seen", d_new, 32'h23);
    step(1, 0, 1, 1, 1, 1, 1, "R6 locked mmap read again");
    chk("R6 flag not cleared", d_new, 32'h23);
    step(1, 0, 0, 1, 1, 0, 0, "R6 debugger read");
    chk("R6 debugger sees flag", d_new, 32'h3);
    step(1, 0, 0, 1, 1, 1, 1, "R6 after debugger clear");
    chk("R6 cleared by debugger", d_new, 32'h1);

    step(1, 1, 1, 0, 1, 0, 1, "R2 core reset read");
    chk("R2 bit0 low in reset", d_new, 32'h22);
    step(1, 0, 0, 0, 1, 1, 0, "R4 reset sets flag");
    chk("R4 flag from reset", d_new, 32'h3);

    for (int i = 0; i < 3000; i++) begin
      logic p, r;
      p = ($urandom % 10) != 0;
      r = ($urandom % 8) == 0;
      step(p, r, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           "R1 R2 R3 R4 R5 R6 R7 R8 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule